// File: doc/BRIEF.md
# Shared RAM Address Decode Arbiter

This block lets two masters use one on-board RAM of 16 KB. The local processor issues 16-bit byte addresses. It sees the whole RAM as one 16 KB block, placed on any 16 KB boundary of its 64 KB space. An external system-bus master issues 20-bit byte addresses. It sees a window of either 8 KB or 16 KB, which can be placed on a matching boundary anywhere in a 1 MB space. Each side has its own comparator and its own base, so the two placements never interact.

A reservation switch keeps the lower 8 KB of RAM for the processor alone. While it is set, the bus can reach only the upper 8 KB. When both masters issue streams of accesses, the single RAM port is shared cycle by cycle. Each granted access returns a one-cycle acknowledge, together with registered RAM-select and port-select outputs. Accesses are whole 32-bit words, and the two lowest address bits are not used.

Top module: `ram_share_arb`

## Requirements
- R1: A processor request is served only when cpu_addr[15:14] equals the processor base latched at reset. RAM word index = cpu_addr[13:2].
- R2: When cfg_win16=0 and cfg_rsv=0, a bus request is served when bus_addr[19:13] equals the bus base. It maps to RAM byte offset bus_addr[12:0], which is the lower 8 KB.
- R3: When cfg_win16=1, a bus request is served when bus_addr[19:14] equals bus base bits [6:1]. Base bit 0 is ignored, and the RAM byte offset is bus_addr[13:0].
- R4: When cfg_rsv=1, an 8 KB bus window maps to the upper half of RAM (byte offset 0x2000 + bus_addr[12:0]). In 16 KB mode, bus addresses with bit 13 = 0 are never acknowledged. The lower half of RAM stays reachable only by the processor.
- R5: Both bases, cfg_win16 and cfg_rsv are captured only while rst is high. Changing them after reset has no effect on decoding.
- R6: A served access gives its port an acknowledge pulse exactly one cycle after the request is accepted, and read data is valid during that pulse. A port is not accepted again while its own acknowledge is high.
- R7: When both ports become eligible in the same cycle, the port not served most recently wins. After reset the processor wins the first tie.
- R8: While both ports request continuously, acknowledges alternate between the ports on consecutive cycles, and each port is served once every two cycles.
- R9: ram_sel is high exactly in cycles with an acknowledge. mux_sel is 1 when that access came from the bus and 0 when it came from the processor.
- R10: In the first cycle after reset is released, cpu_ack, bus_ack, ram_sel and mux_sel are all 0.
- R11: A request whose address misses its port's decoder is never acknowledged and never raises ram_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_cpu_base | input | 2 | Processor-side base, address bits [15:14] |
| cfg_bus_base | input | 7 | Bus-side base, address bits [19:13] |
| cfg_win16 | input | 1 | 1 = 16 KB bus window, 0 = 8 KB |
| cfg_rsv | input | 1 | 1 = lower 8 KB of RAM kept for the processor |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Processor acknowledge pulse |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 20 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Bus acknowledge pulse |
| ram_sel | output | 1 | RAM was accessed in the previous cycle |
| mux_sel | output | 1 | Owner of that access: 1 = bus, 0 = processor |

## Verification
The checker assumes that each master holds its request, address and data steady from the moment it raises the request until its acknowledge arrives. It also assumes that each master updates or drops the request in the acknowledge cycle. The bench meets this by driving every input only at falling edges. It waits for the acknowledge before moving on, and requests that must go unanswered are withdrawn after a fixed wait. Configuration changes are applied only around a new reset, except in the test that changes them on purpose to show they are ignored.

// File: rtl/ram_share_pkg.sv
package ram_share_pkg;
  typedef enum logic {PORT_CPU = 1'b0, PORT_BUS = 1'b1} port_t;
endpackage

// File: rtl/ram_share_cpu_dec.sv
module ram_share_cpu_dec #(
  parameter int CPU_AW = 16,
  parameter int RAM_AW = 14,
  parameter int LSB    = 2
) (
  input  logic [CPU_AW-1:0]      addr,
  input  logic [CPU_AW-RAM_AW-1:0] base,
  output logic                   hit,
  output logic [RAM_AW-LSB-1:0]  word
);
  assign hit  = (addr[CPU_AW-1:RAM_AW] == base);
  assign word = addr[RAM_AW-1:LSB];

  generate
    if (LSB > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^addr[LSB-1:0];
    end
  endgenerate
endmodule

// File: rtl/ram_share_bus_dec.sv
module ram_share_bus_dec #(
  parameter int BUS_AW = 20,
  parameter int SEG_AW = 13,
  parameter int LSB    = 2
) (
  input  logic [BUS_AW-1:0]        addr,
  input  logic [BUS_AW-SEG_AW-1:0] base,
  input  logic                     win16,
  input  logic                     rsv,
  output logic                     hit,
  output logic [SEG_AW-LSB:0]      word
);
  logic seg_eq, pair_eq, upper;

  // 8 KB window compares every base bit; 16 KB window drops base bit 0
  assign seg_eq  = (addr[BUS_AW-1:SEG_AW] == base);
  assign pair_eq = (addr[BUS_AW-1:SEG_AW+1] == base[BUS_AW-SEG_AW-1:1]);
  // RAM half: chosen by the address in 16 KB mode, by the reservation otherwise
  assign upper   = win16 ? addr[SEG_AW] : rsv;
  assign hit     = (win16 ? pair_eq : seg_eq) && !(rsv && !upper);
  assign word    = {upper, addr[SEG_AW-1:LSB]};

  generate
    if (LSB > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^addr[LSB-1:0];
    end
  endgenerate
endmodule

// File: rtl/ram_share_rr.sv
module ram_share_rr
  import ram_share_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic elig_cpu,
  input  logic elig_bus,
  output logic gnt_cpu,
  output logic gnt_bus
);
  port_t last_q;

  assign gnt_cpu = elig_cpu && (!elig_bus || last_q == PORT_BUS);
  assign gnt_bus = elig_bus && !gnt_cpu;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= PORT_BUS;
    else if (gnt_cpu) last_q <= PORT_CPU;
    else if (gnt_bus) last_q <= PORT_BUS;
  end
endmodule

// File: rtl/ram_share_mem.sv
module ram_share_mem #(
  parameter int DATA_W = 32,
  parameter int WORD_AW = 12
) (
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ram_share_arb.sv
module ram_share_arb #(
  parameter int DATA_W = 32,
  parameter int CPU_AW = 16,
  parameter int BUS_AW = 20,
  parameter int SEG_AW = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CPU_AW-SEG_AW-2:0] cfg_cpu_base,
  input  logic [BUS_AW-SEG_AW-1:0] cfg_bus_base,
  input  logic                     cfg_win16,
  input  logic                     cfg_rsv,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_ack,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_ack,
  output logic                     ram_sel,
  output logic                     mux_sel
);
  localparam int RAM_AW  = SEG_AW + 1;
  localparam int LSB     = $clog2(DATA_W / 8);
  localparam int WORD_AW = RAM_AW - LSB;

  // configuration, captured only during reset
  logic [CPU_AW-RAM_AW-1:0] cpu_base_q;
  logic [BUS_AW-SEG_AW-1:0] bus_base_q;
  logic                     win16_q, rsv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_base_q <= cfg_cpu_base;
      bus_base_q <= cfg_bus_base;
      win16_q    <= cfg_win16;
      rsv_q      <= cfg_rsv;
    end
  end

  logic               cpu_hit, bus_hit;
  logic [WORD_AW-1:0] cpu_word, bus_word;

  ram_share_cpu_dec #(.CPU_AW(CPU_AW), .RAM_AW(RAM_AW), .LSB(LSB)) u_cpu_dec (
    .addr (cpu_addr),
    .base (cpu_base_q),
    .hit  (cpu_hit),
    .word (cpu_word)
  );

  ram_share_bus_dec #(.BUS_AW(BUS_AW), .SEG_AW(SEG_AW), .LSB(LSB)) u_bus_dec (
    .addr  (bus_addr),
    .base  (bus_base_q),
    .win16 (win16_q),
    .rsv   (rsv_q),
    .hit   (bus_hit),
    .word  (bus_word)
  );

  // a port whose acknowledge is showing cannot be accepted again this cycle
  logic elig_cpu, elig_bus, gnt_cpu, gnt_bus, gnt_any;
  assign elig_cpu = cpu_req && cpu_hit && !cpu_ack;
  assign elig_bus = bus_req && bus_hit && !bus_ack;

  ram_share_rr u_rr (
    .clk      (clk),
    .rst      (rst),
    .elig_cpu (elig_cpu),
    .elig_bus (elig_bus),
    .gnt_cpu  (gnt_cpu),
    .gnt_bus  (gnt_bus)
  );

  assign gnt_any = gnt_cpu || gnt_bus;

  logic [WORD_AW-1:0] m_addr;
  logic [DATA_W-1:0]  m_wdata, m_rdata;
  logic               m_we;

  always_comb begin
    if (gnt_bus) begin
      m_addr  = bus_word;
      m_wdata = bus_wdata;
      m_we    = bus_we;
    end else begin
      m_addr  = cpu_word;
      m_wdata = cpu_wdata;
      m_we    = cpu_we;
    end
  end

  ram_share_mem #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_mem (
    .clk   (clk),
    .en    (gnt_any),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ack <= 1'b0;
      bus_ack <= 1'b0;
      ram_sel <= 1'b0;
      mux_sel <= 1'b0;
    end else begin
      cpu_ack <= gnt_cpu;
      bus_ack <= gnt_bus;
      ram_sel <= gnt_any;
      mux_sel <= gnt_bus;
    end
  end

  assign cpu_rdata = m_rdata;
  assign bus_rdata = m_rdata;
endmodule

// File: rtl/ram_share_chk.sv
module ram_share_chk #(
  parameter int CPU_AW = 16,
  parameter int BUS_AW = 20,
  parameter int SEG_AW = 13
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CPU_AW-SEG_AW-2:0] cfg_cpu_base,
  input logic                     cfg_win16,
  input logic                     cfg_rsv,
  input logic                     cpu_req,
  input logic [CPU_AW-1:0]        cpu_addr,
  input logic                     cpu_ack,
  input logic                     bus_req,
  input logic [BUS_AW-1:0]        bus_addr,
  input logic                     bus_ack,
  input logic                     ram_sel,
  input logic                     mux_sel
);
  logic [CPU_AW-SEG_AW-2:0] cb_q;
  logic                     w16_q, rs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cb_q  <= cfg_cpu_base;
      w16_q <= cfg_win16;
      rs_q  <= cfg_rsv;
    end
  end

  a_r1_cpu_decode: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> $past(cpu_req && cpu_addr[CPU_AW-1:SEG_AW+1] == cb_q));

  a_r4_reserved_half: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(!(rs_q && w16_q && !bus_addr[SEG_AW])));

  a_r6_single_pulse_cpu: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  a_r6_single_pulse_bus: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  a_r8_one_owner: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ack && bus_ack));

  a_r9_select_on_ack: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack || bus_ack) |-> ram_sel);

  a_r9_mux_owner: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (mux_sel == bus_ack) && (cpu_ack || bus_ack));

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cpu_ack && !bus_ack && !ram_sel && !mux_sel);

  a_r11_bus_needs_request: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));
endmodule

bind ram_share_arb ram_share_chk #(
  .CPU_AW(CPU_AW), .BUS_AW(BUS_AW), .SEG_AW(SEG_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_cpu_base (cfg_cpu_base),
  .cfg_win16    (cfg_win16),
  .cfg_rsv      (cfg_rsv),
  .cpu_req      (cpu_req),
  .cpu_addr     (cpu_addr),
  .cpu_ack      (cpu_ack),
  .bus_req      (bus_req),
  .bus_addr     (bus_addr),
  .bus_ack      (bus_ack),
  .ram_sel      (ram_sel),
  .mux_sel      (mux_sel)
);

// File: tb/ram_share_arb_tb.sv
module ram_share_arb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_cpu_base;
  logic [6:0]  cfg_bus_base;
  logic        cfg_win16, cfg_rsv;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_ack;
  logic        bus_req, bus_we;
  logic [19:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ack, ram_sel, mux_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ram_share_arb u_dut (
    .clk(clk), .rst(rst),
    .cfg_cpu_base(cfg_cpu_base), .cfg_bus_base(cfg_bus_base),
    .cfg_win16(cfg_win16), .cfg_rsv(cfg_rsv),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .ram_sel(ram_sel), .mux_sel(mux_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cb, input logic [6:0] bb, input logic w16, input logic rs);
    @(negedge clk);
    rst = 1'b1; cpu_req = 1'b0; bus_req = 1'b0;
    cfg_cpu_base = cb; cfg_bus_base = bb; cfg_win16 = w16; cfg_rsv = rs;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // processor access; got=0 if no acknowledge within 6 cycles
  task automatic cpu_xfer(input logic we, input logic [15:0] a, input logic [31:0] d,
                          output logic got, output logic [31:0] rd, output int lat,
                          output logic rs_seen, output logic mx_seen);
    got = 1'b0; rd = '0; lat = 0; rs_seen = 1'b0; mx_seen = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      rs_seen = rs_seen | ram_sel;
      if (cpu_ack) begin
        got = 1'b1; rd = cpu_rdata; lat = i; mx_seen = mux_sel;
        break;
      end
    end
    cpu_req = 1'b0;
  endtask

  task automatic bus_xfer(input logic we, input logic [19:0] a, input logic [31:0] d,
                          output logic got, output logic [31:0] rd, output int lat,
                          output logic rs_seen, output logic mx_seen);
    got = 1'b0; rd = '0; lat = 0; rs_seen = 1'b0; mx_seen = 1'b0;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      rs_seen = rs_seen | ram_sel;
      if (bus_ack) begin
        got = 1'b1; rd = bus_rdata; lat = i; mx_seen = mux_sel;
        break;
      end
    end
    bus_req = 1'b0;
  endtask

  logic        g, rs, mx;
  logic [31:0] rd;
  int          lat;

  task automatic t_reset_state();
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 cpu_ack", {31'b0, cpu_ack}, 32'd0);
    check("R10 bus_ack", {31'b0, bus_ack}, 32'd0);
    check("R10 ram_sel/mux_sel", {30'b0, ram_sel, mux_sel}, 32'd0);
  endtask

  task automatic t_cpu_basic();
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    cpu_xfer(1'b1, 16'h8010, 32'hC0DE_0001, g, rd, lat, rs, mx);
    check("R6 cpu write ack latency", lat, 1);
    check("R9 cpu mux_sel", {31'b0, mx}, 32'd0);
    cpu_xfer(1'b0, 16'h8010, 32'h0, g, rd, lat, rs, mx);
    check("R6 cpu read data", rd, 32'hC0DE_0001);
    cpu_xfer(1'b0, 16'h4010, 32'h0, g, rd, lat, rs, mx);
    check("R1 cpu base mismatch no ack", {31'b0, g}, 32'd0);
    check("R11 miss leaves ram_sel low", {31'b0, rs}, 32'd0);
  endtask

  task automatic t_bus_8k();
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    bus_xfer(1'b1, 20'h64020, 32'hB5B5_0002, g, rd, lat, rs, mx);
    check("R2 bus 8K hit", {31'b0, g}, 32'd1);
    check("R9 bus ram_sel/mux_sel", {30'b0, rs, mx}, 32'd3);
    cpu_xfer(1'b0, 16'h8020, 32'h0, g, rd, lat, rs, mx);
    check("R2 lower half mapping", rd, 32'hB5B5_0002);
    bus_xfer(1'b0, 20'h66020, 32'h0, g, rd, lat, rs, mx);
    check("R11 bus outside 8K window", {31'b0, g}, 32'd0);
  endtask

  task automatic t_bus_16k();
    do_reset(2'b10, 7'h33, 1'b1, 1'b0);
    bus_xfer(1'b1, 20'h66040, 32'h1616_0003, g, rd, lat, rs, mx);
    check("R3 16K window base bit0 ignored", {31'b0, g}, 32'd1);
    cpu_xfer(1'b0, 16'hA040, 32'h0, g, rd, lat, rs, mx);
    check("R3 offset 0x2040 mapping", rd, 32'h1616_0003);
    bus_xfer(1'b1, 20'h64044, 32'h1616_0004, g, rd, lat, rs, mx);
    cpu_xfer(1'b0, 16'h8044, 32'h0, g, rd, lat, rs, mx);
    check("R3 offset 0x0044 mapping", rd, 32'h1616_0004);
  endtask

  task automatic t_reserve();
    do_reset(2'b10, 7'h32, 1'b0, 1'b1);
    bus_xfer(1'b1, 20'h64080, 32'hAAAA_0005, g, rd, lat, rs, mx);
    cpu_xfer(1'b0, 16'hA080, 32'h0, g, rd, lat, rs, mx);
    check("R4 reserved 8K maps upper", rd, 32'hAAAA_0005);
    cpu_xfer(1'b1, 16'h8080, 32'h5555_0006, g, rd, lat, rs, mx);
    bus_xfer(1'b0, 20'h64080, 32'h0, g, rd, lat, rs, mx);
    check("R4 bus cannot see lower half", rd, 32'hAAAA_0005);
    do_reset(2'b10, 7'h32, 1'b1, 1'b1);
    bus_xfer(1'b0, 20'h64100, 32'h0, g, rd, lat, rs, mx);
    check("R4 16K reserved half no ack", {30'b0, g, rs}, 32'd0);
    bus_xfer(1'b0, 20'h66080, 32'h0, g, rd, lat, rs, mx);
    check("R4 16K upper half served", rd, 32'hAAAA_0005);
  endtask

  task automatic t_cfg_sampling();
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    @(negedge clk);
    cfg_cpu_base = 2'b01; cfg_bus_base = 7'h10; cfg_win16 = 1'b1;
    cpu_xfer(1'b0, 16'h4000, 32'h0, g, rd, lat, rs, mx);
    check("R5 new cpu base ignored", {31'b0, g}, 32'd0);
    cpu_xfer(1'b0, 16'h8000, 32'h0, g, rd, lat, rs, mx);
    check("R5 old cpu base kept", {31'b0, g}, 32'd1);
    bus_xfer(1'b0, 20'h20000, 32'h0, g, rd, lat, rs, mx);
    check("R5 new bus base ignored", {31'b0, g}, 32'd0);
    bus_xfer(1'b0, 20'h66000, 32'h0, g, rd, lat, rs, mx);
    check("R5 window size kept at 8K", {31'b0, g}, 32'd0);
  endtask

  task automatic t_tie();
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    cpu_we = 1'b0; bus_we = 1'b0; cpu_addr = 16'h8200; bus_addr = 20'h64200;
    cpu_req = 1'b1; bus_req = 1'b1;
    @(negedge clk);
    check("R7 first tie after reset goes to cpu", {30'b0, cpu_ack, bus_ack}, 32'd2);
    cpu_req = 1'b0;
    @(negedge clk);
    check("R7 loser served next", {30'b0, cpu_ack, bus_ack}, 32'd1);
    bus_req = 1'b0;
    repeat (2) @(negedge clk);
    cpu_xfer(1'b0, 16'h8200, 32'h0, g, rd, lat, rs, mx);
    @(negedge clk);
    cpu_req = 1'b1; bus_req = 1'b1;
    @(negedge clk);
    check("R7 tie after cpu access goes to bus", {30'b0, cpu_ack, bus_ack}, 32'd1);
    cpu_req = 1'b0; bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_interleave();
    int nc = 0, nb = 0, prev = -1, bad = 0;
    do_reset(2'b10, 7'h32, 1'b0, 1'b0);
    cpu_we = 1'b1; bus_we = 1'b1;
    cpu_addr = 16'h8100; cpu_wdata = 32'hC100_0000;
    bus_addr = 20'h64300; bus_wdata = 32'hB300_0000;
    cpu_req = 1'b1; bus_req = 1'b1;
    for (int cyc = 0; cyc < 12; cyc++) begin
      @(negedge clk);
      if (cpu_ack == bus_ack) bad++;
      if (cpu_ack) begin
        if (prev == 0) bad++;
        prev = 0; nc++;
        cpu_addr = cpu_addr + 16'd4; cpu_wdata = cpu_wdata + 32'd1;
        if (nc == 6) cpu_req = 1'b0;
      end
      if (bus_ack) begin
        if (prev == 1) bad++;
        prev = 1; nb++;
        bus_addr = bus_addr + 20'd4; bus_wdata = bus_wdata + 32'd1;
        if (nb == 6) bus_req = 1'b0;
      end
    end
    cpu_req = 1'b0; bus_req = 1'b0;
    check("R8 cpu served 6 of 12 cycles", nc, 6);
    check("R8 bus served 6 of 12 cycles", nb, 6);
    check("R8 strict alternation", bad, 0);
    cpu_xfer(1'b0, 16'h8314, 32'h0, g, rd, lat, rs, mx);
    check("R8 bus stream data landed", rd, 32'hB300_0005);
    bus_xfer(1'b0, 20'h64108, 32'h0, g, rd, lat, rs, mx);
    check("R8 cpu stream data landed", rd, 32'hC100_0002);
  endtask

  initial begin
    rst = 1'b1; cpu_req = 1'b0; bus_req = 1'b0; cpu_we = 1'b0; bus_we = 1'b0;
    cpu_addr = '0; bus_addr = '0; cpu_wdata = '0; bus_wdata = '0;
    cfg_cpu_base = '0; cfg_bus_base = '0; cfg_win16 = 1'b0; cfg_rsv = 1'b0;
    t_reset_state();
    t_cpu_basic();
    t_bus_8k();
    t_bus_16k();
    t_reserve();
    t_cfg_sampling();
    t_tie();
    t_interleave();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule